// File: doc/BRIEF.md
# Vector Scalar Move Unit

This unit decodes and executes the two integer scalar-move operations of a vector extension. One copies element 0 of a vector register into an integer register. The other places an integer operand into element 0 of a vector register. Each strobed instruction is finished in one clock. Its results come out as registered one-cycle pulses: an illegal-instruction flag, an integer writeback, or a byte-enabled element write to the vector register file together with a vector-state-dirty pulse.

The read port onto the vector register file is combinational. The unit drives the source register index, and the file returns the low ELEN bits of that register in the same cycle. The operand width is chosen by a selected-element-width code. The integer width is either 32 or 64 bits. Register grouping and masking play no part. Only the single named register is touched, and only its element 0. The bytes above the element width are left as they are.

Top module: `vsmv_unit`

## Requirements
- R1: An instruction is recognised only when bits [6:0] are 1010111, bits [31:26] are 010000 and bit 25 is 1. Vector-to-integer: bits [14:12] = 010 and bits [19:15] = 0. Integer-to-vector: bits [14:12] = 110 and bits [24:20] = 0. Any other strobed word raises `illegal`.
- R2: Vector-to-integer drives `vrf_rd_idx` with bits [24:20] in the same cycle. One cycle after the strobe it writes the low 8<<`sew` bits of `vrf_rd_data`, sign-extended, to register bits [11:7]. `xlen64`=1 selects a 64-bit integer width. With `xlen64`=0 the result is sign-extended to 32 bits and output bits [63:32] are zero.
- R3: A vector-to-integer move whose destination is register 0 produces no integer writeback.
- R4: Integer-to-vector takes the operand at integer width and sign-extends it to 64 bits: all of `rs1_data` when `xlen64`=1, otherwise its low 32 bits. It drives that value on `vwr_data`, drives bits [11:7] on `vwr_idx`, and sets the low 2^`sew` bits of `vwr_be`. This happens one cycle after the strobe.
- R5: An integer-to-vector move with `vl` = 0 makes no element write and no dirty pulse.
- R6: A source index of 0 in bits [19:15] is not special: the element write still happens with the operand supplied.
- R7: `vs_dirty` pulses in exactly the cycles that carry a vector element write.
- R8: `illegal` is raised, and every write is suppressed, in these cases: `vec_on`=0, `vcfg_ok`=0, a `sew` code of 4 to 7 (0/1/2/3 mean 8/16/32/64 bits), or a `sew` code of 3 with `xlen64`=0.
- R9: After reset, and in any cycle after one without a strobe, all output pulses and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| vec_on | input | 1 | Vector unit enabled |
| vcfg_ok | input | 1 | Vector configuration valid |
| sew | input | 3 | Element width code |
| vl | input | VL_W | Current vector length |
| xlen64 | input | 1 | 1: 64-bit integer width, 0: 32-bit |
| rs1_data | input | ELEN | Integer source operand |
| vrf_rd_idx | output | 5 | Vector register read index |
| vrf_rd_data | input | ELEN | Low ELEN bits of the read register |
| illegal | output | 1 | Illegal-instruction pulse |
| xwb_en | output | 1 | Integer writeback enable |
| xwb_idx | output | 5 | Integer destination index |
| xwb_data | output | ELEN | Integer writeback data |
| vwr_en | output | 1 | Vector element write enable |
| vwr_idx | output | 5 | Vector destination register |
| vwr_data | output | ELEN | Element write data |
| vwr_be | output | ELEN/8 | Element write byte enables |
| vs_dirty | output | 1 | Vector-state-dirty pulse |

## Verification
The element write and the dirty pulse share a cycle. Both are gated by the same conditions: legality and a non-zero `vl`. The bench provokes them together with integer-to-vector moves at several widths, then drops `vl` to zero or makes the instruction illegal, and checks that both vanish together. A behavioural model predicts every output field for each clock. A move into a register followed by a move back out of it checks that the written element and the preserved upper bytes read back as expected.

// File: rtl/vsmv_pkg.sv
package vsmv_pkg;
    localparam logic [6:0] OPC_VEC     = 7'b1010111;
    localparam logic [5:0] F6_SMOVE    = 6'b010000;
    localparam logic [2:0] F3_TO_INT   = 3'b010;
    localparam logic [2:0] F3_FROM_INT = 3'b110;
    localparam int         RIW         = 5;

    typedef enum logic [1:0] {
        MV_NONE,
        MV_TO_INT,
        MV_FROM_INT
    } mv_kind_e;

    typedef struct packed {
        mv_kind_e         kind;
        logic [RIW-1:0]   dst;
        logic [RIW-1:0]   vsrc;
    } mv_dec_t;
endpackage

// File: rtl/vsmv_decode.sv
module vsmv_decode
    import vsmv_pkg::*;
(
    input  logic [31:0] instr,
    output mv_dec_t     dec
);
    logic base_ok;

    always_comb begin
        base_ok  = (instr[6:0] == OPC_VEC) && (instr[31:26] == F6_SMOVE) && instr[25];
        dec.kind = MV_NONE;
        dec.dst  = instr[11:7];
        dec.vsrc = instr[24:20];
        if (base_ok && instr[14:12] == F3_TO_INT && instr[19:15] == '0)
            dec.kind = MV_TO_INT;
        else if (base_ok && instr[14:12] == F3_FROM_INT && instr[24:20] == '0)
            dec.kind = MV_FROM_INT;
    end
endmodule

// File: rtl/vsmv_sext.sv
module vsmv_sext #(
    parameter int W = 64
) (
    input  logic [W-1:0]              raw,
    input  logic [$clog2($clog2(W/8)+1)-1:0] wsel,
    output logic [W-1:0]              ext
);
    localparam int NW = $clog2(W/8) + 1;

    logic [W-1:0] cand [NW];

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int EW = 8 << g;
        if (EW >= W) begin : g_full
            assign cand[g] = raw;
        end else begin : g_part
            assign cand[g] = {{(W-EW){raw[EW-1]}}, raw[EW-1:0]};
        end
    end

    assign ext = cand[wsel];
endmodule

// File: rtl/vsmv_unit.sv
module vsmv_unit
    import vsmv_pkg::*;
#(
    parameter int ELEN = 64,
    parameter int VL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic              vec_on,
    input  logic              vcfg_ok,
    input  logic [2:0]        sew,
    input  logic [VL_W-1:0]   vl,
    input  logic              xlen64,
    input  logic [ELEN-1:0]   rs1_data,
    output logic [RIW-1:0]    vrf_rd_idx,
    input  logic [ELEN-1:0]   vrf_rd_data,
    output logic              illegal,
    output logic              xwb_en,
    output logic [RIW-1:0]    xwb_idx,
    output logic [ELEN-1:0]   xwb_data,
    output logic              vwr_en,
    output logic [RIW-1:0]    vwr_idx,
    output logic [ELEN-1:0]   vwr_data,
    output logic [ELEN/8-1:0] vwr_be,
    output logic              vs_dirty
);
    localparam int NB = ELEN / 8;
    localparam int SW = $clog2($clog2(NB) + 1);

    typedef struct packed {
        logic            illegal;
        logic            xwb_en;
        logic [RIW-1:0]  xwb_idx;
        logic [ELEN-1:0] xwb_data;
        logic            vwr_en;
        logic [RIW-1:0]  vwr_idx;
        logic [ELEN-1:0] vwr_data;
        logic [NB-1:0]   vwr_be;
        logic            vs_dirty;
    } out_t;

    mv_dec_t         dec;
    logic [ELEN-1:0] elem_ext;
    logic [ELEN-1:0] op_ext;
    logic [SW-1:0]   op_wsel;
    logic [NB-1:0]   be_mask;
    logic            bad_sew;
    out_t            out_d, out_q;

    vsmv_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    vsmv_sext #(.W(ELEN)) u_elem_ext (
        .raw  (vrf_rd_data),
        .wsel (sew[SW-1:0]),
        .ext  (elem_ext)
    );

    assign op_wsel = xlen64 ? SW'(3) : SW'(2);

    vsmv_sext #(.W(ELEN)) u_op_ext (
        .raw  (rs1_data),
        .wsel (op_wsel),
        .ext  (op_ext)
    );

    assign vrf_rd_idx = dec.vsrc;

    always_comb begin
        for (int b = 0; b < NB; b++)
            be_mask[b] = (b < (1 << sew[SW-1:0]));
    end

    always_comb begin
        out_d   = '0;
        bad_sew = sew[2] || (sew[1:0] == 2'd3 && !xlen64);
        if (in_valid) begin
            if (dec.kind == MV_NONE || !vec_on || !vcfg_ok || bad_sew) begin
                out_d.illegal = 1'b1;
            end else if (dec.kind == MV_TO_INT) begin
                if (dec.dst != '0) begin
                    out_d.xwb_en   = 1'b1;
                    out_d.xwb_idx  = dec.dst;
                    out_d.xwb_data = xlen64 ? elem_ext
                                            : {{(ELEN-32){1'b0}}, elem_ext[31:0]};
                end
            end else if (vl != '0) begin
                out_d.vwr_en   = 1'b1;
                out_d.vwr_idx  = dec.dst;
                out_d.vwr_data = op_ext;
                out_d.vwr_be   = be_mask;
                out_d.vs_dirty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign illegal  = out_q.illegal;
    assign xwb_en   = out_q.xwb_en;
    assign xwb_idx  = out_q.xwb_idx;
    assign xwb_data = out_q.xwb_data;
    assign vwr_en   = out_q.vwr_en;
    assign vwr_idx  = out_q.vwr_idx;
    assign vwr_data = out_q.vwr_data;
    assign vwr_be   = out_q.vwr_be;
    assign vs_dirty = out_q.vs_dirty;

    p_illegal_blocks_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!xwb_en && !vwr_en && !vs_dirty));

    p_vl_zero_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vl == '0) |=> !vwr_en);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!illegal && !xwb_en && !vwr_en && !vs_dirty));

    p_no_x0_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xwb_en |-> (xwb_idx != '0));

    p_be_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vwr_en |-> (vwr_be[0] && ((vwr_be & (vwr_be + 1'b1)) == '0)));

    p_dirty_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vs_dirty |-> vwr_en);

    p_single_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({illegal, xwb_en, vwr_en}));
endmodule

// File: tb/vsmv_unit_test.sv
module vsmv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic        vec_on, vcfg_ok, xlen64;
    logic [2:0]  sew;
    logic [15:0] vl;
    logic [63:0] rs1_data;
    logic [4:0]  vrf_rd_idx;
    logic [63:0] vrf_rd_data;
    logic        illegal, xwb_en, vwr_en, vs_dirty;
    logic [4:0]  xwb_idx, vwr_idx;
    logic [63:0] xwb_data, vwr_data;
    logic [7:0]  vwr_be;

    logic [63:0] vrf [32];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vsmv_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .vec_on(vec_on), .vcfg_ok(vcfg_ok), .sew(sew), .vl(vl),
        .xlen64(xlen64), .rs1_data(rs1_data), .vrf_rd_idx(vrf_rd_idx),
        .vrf_rd_data(vrf_rd_data), .illegal(illegal), .xwb_en(xwb_en),
        .xwb_idx(xwb_idx), .xwb_data(xwb_data), .vwr_en(vwr_en),
        .vwr_idx(vwr_idx), .vwr_data(vwr_data), .vwr_be(vwr_be),
        .vs_dirty(vs_dirty)
    );

    assign vrf_rd_data = vrf[vrf_rd_idx];

    always @(posedge clk) begin
        if (vwr_en) begin
            for (int b = 0; b < 8; b++)
                if (vwr_be[b]) vrf[vwr_idx][b*8 +: 8] <= vwr_data[b*8 +: 8];
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx(logic [63:0] v, int w);
        logic [63:0] m;
        if (w >= 64) return v;
        m = (64'd1 << w) - 64'd1;
        return v[w-1] ? ((v & m) | ~m) : (v & m);
    endfunction

    function automatic logic [31:0] enc(logic [5:0] f6, logic vm, logic [4:0] a,
                                        logic [4:0] b, logic [2:0] f3, logic [4:0] d);
        return {f6, vm, a, b, f3, d, 7'b1010111};
    endfunction

    task automatic expect_all(string tag, logic e_ill, logic e_xen, logic [4:0] e_xidx,
                              logic [63:0] e_xdat, logic e_ven, logic [4:0] e_vidx,
                              logic [63:0] e_vdat, logic [7:0] e_be);
        chk(tag, "illegal", 64'(illegal), 64'(e_ill));
        chk(tag, "xwb_en", 64'(xwb_en), 64'(e_xen));
        if (e_xen) begin
            chk(tag, "xwb_idx", 64'(xwb_idx), 64'(e_xidx));
            chk(tag, "xwb_data", xwb_data, e_xdat);
        end
        chk(tag, "vwr_en", 64'(vwr_en), 64'(e_ven));
        chk(tag, "vs_dirty", 64'(vs_dirty), 64'(e_ven));
        if (e_ven) begin
            chk(tag, "vwr_idx", 64'(vwr_idx), 64'(e_vidx));
            chk(tag, "vwr_data", vwr_data, e_vdat);
            chk(tag, "vwr_be", 64'(vwr_be), 64'(e_be));
        end
    endtask

    // Drive one instruction at a falling edge, predict from the requirements,
    // compare at the next falling edge (one register stage), then one idle cycle.
    task automatic run(string tag, logic [31:0] iw, logic on, logic ok, logic [2:0] sw,
                       logic [15:0] len, logic x64, logic [63:0] op);
        logic is_v, to_int, from_int, bad, e_ill, e_xen, e_ven;
        logic [63:0] e_xdat, e_vdat;
        logic [7:0]  e_be;
        in_valid = 1'b1; instr = iw; vec_on = on; vcfg_ok = ok;
        sew = sw; vl = len; xlen64 = x64; rs1_data = op;
        #1;
        chk("R2", "vrf_rd_idx", 64'(vrf_rd_idx), 64'(iw[24:20]));
        is_v     = iw[6:0] == 7'b1010111 && iw[31:26] == 6'b010000 && iw[25];
        to_int   = is_v && iw[14:12] == 3'b010 && iw[19:15] == 5'd0;
        from_int = is_v && iw[14:12] == 3'b110 && iw[24:20] == 5'd0;
        bad      = sw > 3 || (sw == 3 && !x64);
        e_ill    = !(to_int || from_int) || !on || !ok || bad;
        e_xen    = !e_ill && to_int && iw[11:7] != 0;
        e_ven    = !e_ill && from_int && len != 0;
        e_xdat   = e_xen ? sx(vrf[iw[24:20]], 8 << sw) : 64'd0;
        if (!x64) e_xdat = {32'd0, e_xdat[31:0]};
        e_vdat   = x64 ? op : sx(op, 32);
        e_be     = 8'((16'd1 << (1 << sw[1:0])) - 16'd1);
        @(negedge clk);
        expect_all(tag, e_ill, e_xen, iw[11:7], e_xdat, e_ven, iw[11:7], e_vdat, e_be);
        in_valid = 1'b0;
        @(negedge clk);
        expect_all("R9", 1'b0, 1'b0, 5'd0, 64'd0, 1'b0, 5'd0, 64'd0, 8'd0);
    endtask

    localparam logic [5:0] F6 = 6'b010000;

    initial begin
        #800000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) vrf[i] = {8{8'(i * 17 + 3)}};
        vrf[3] = 64'h1122_3344_5566_7780;
        vrf[4] = 64'h0123_4567_89AB_7FFE;
        vrf[6] = 64'hFFFF_0000_8000_0001;
        vrf[7] = 64'h8765_4321_0FED_CBA9;
        rst_n = 1'b0; in_valid = 1'b0; instr = '0; vec_on = 1'b1; vcfg_ok = 1'b1;
        sew = 3'd0; vl = 16'd4; xlen64 = 1'b1; rs1_data = '0;
        repeat (3) @(negedge clk);
        expect_all("R9", 1'b0, 1'b0, 5'd0, 64'd0, 1'b0, 5'd0, 64'd0, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: element 0 to integer at each width
        run("R2", enc(F6, 1, 5'd3, 5'd0, 3'b010, 5'd9),  1, 1, 3'd0, 16'd4, 1, 0);
        run("R2", enc(F6, 1, 5'd4, 5'd0, 3'b010, 5'd10), 1, 1, 3'd1, 16'd4, 1, 0);
        run("R2", enc(F6, 1, 5'd6, 5'd0, 3'b010, 5'd11), 1, 1, 3'd2, 16'd4, 0, 0);
        run("R2", enc(F6, 1, 5'd7, 5'd0, 3'b010, 5'd12), 1, 1, 3'd3, 16'd1, 1, 0);
        // R3: destination 0 discarded
        run("R3", enc(F6, 1, 5'd3, 5'd0, 3'b010, 5'd0),  1, 1, 3'd0, 16'd4, 1, 0);
        // R4 / R7: integer into element 0
        run("R4", enc(F6, 1, 5'd0, 5'd8, 3'b110, 5'd5),  1, 1, 3'd0, 16'd3, 1, 64'h0000_0000_0000_FF92);
        run("R4", enc(F6, 1, 5'd0, 5'd8, 3'b110, 5'd6),  1, 1, 3'd2, 16'd2, 0, 64'hDEAD_BEEF_8000_0001);
        run("R7", enc(F6, 1, 5'd0, 5'd9, 3'b110, 5'd7),  1, 1, 3'd3, 16'd1, 1, 64'hCAFE_0000_1234_5678);
        // R2 read-back of what R4 wrote: low byte 0x92, upper bytes kept
        run("R2", enc(F6, 1, 5'd5, 5'd0, 3'b010, 5'd13), 1, 1, 3'd1, 16'd4, 1, 0);
        // R5: vl zero suppresses write and dirty
        run("R5", enc(F6, 1, 5'd0, 5'd8, 3'b110, 5'd5),  1, 1, 3'd0, 16'd0, 1, 64'h55);
        run("R2", enc(F6, 1, 5'd5, 5'd0, 3'b010, 5'd14), 1, 1, 3'd0, 16'd4, 1, 0);
        // R6: source index 0 still writes
        run("R6", enc(F6, 1, 5'd0, 5'd0, 3'b110, 5'd8),  1, 1, 3'd1, 16'd2, 1, 64'd0);
        // R8: illegal cases
        run("R8", enc(F6, 1, 5'd3, 5'd0, 3'b010, 5'd9),  0, 1, 3'd0, 16'd4, 1, 0);
        run("R8", enc(F6, 1, 5'd0, 5'd2, 3'b110, 5'd9),  1, 0, 3'd0, 16'd4, 1, 64'h7);
        run("R8", enc(F6, 1, 5'd0, 5'd2, 3'b110, 5'd9),  1, 1, 3'd5, 16'd4, 1, 64'h7);
        run("R8", enc(F6, 1, 5'd7, 5'd0, 3'b010, 5'd9),  1, 1, 3'd3, 16'd4, 0, 0);
        // R1: malformed encodings
        run("R1", enc(F6, 0, 5'd3, 5'd0, 3'b010, 5'd9),  1, 1, 3'd0, 16'd4, 1, 0);
        run("R1", enc(F6, 1, 5'd3, 5'd1, 3'b010, 5'd9),  1, 1, 3'd0, 16'd4, 1, 0);
        run("R1", enc(F6, 1, 5'd2, 5'd4, 3'b110, 5'd9),  1, 1, 3'd0, 16'd4, 1, 64'h1);
        run("R1", enc(6'b010001, 1, 5'd3, 5'd0, 3'b010, 5'd9), 1, 1, 3'd0, 16'd4, 1, 0);
        run("R1", enc(F6, 1, 5'd3, 5'd0, 3'b010, 5'd9) ^ 32'h1, 1, 1, 3'd0, 16'd4, 1, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule